// File: doc/BRIEF.md
# Slow-Control Register Bridge

This block sits on a host local bus and turns register accesses into slow-control messages for a remote front end that is reached over a serial link. The link protocol engine is not part of the block. The block meets it at a single message port with a valid/ready handshake, and it takes reply messages on a separate input that is always ready.

Address 0x00 is a stream port. Each byte written there leaves as a stream message straight away, so a large configuration file can be poured through one address. Any other address is a posted register write. The value is kept in a write RAM and the address is queued in a pending-address FIFO. A packetizer takes addresses from that FIFO and emits configuration messages that carry the RAM content.

Remote reads take two host accesses. The first read of an address sends a read request and returns a not-ready flag. The reply lands in a read RAM. The next read of the same address then returns the value and closes the handshake. Reading address 0x00 returns the handshake status.

Top module: `sc_reg_bridge`

## Requirements
- R1: After reset `msg_valid` and `bus_busy` are 0, and a read of address 0x00 returns 0 with `bus_rnack` clear.
- R2: A write to address 0x00, made while the message port is idle, is presented on the port at the next clock edge. It has kind 1 (stream), address 0 and the written byte as data. It is not delayed by queued register writes.
- R3: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_kind`, `msg_addr` and `msg_data` hold their values.
- R4: A write to a nonzero address produces exactly one message of kind 2 (configuration), with that address and data. Such messages leave in the order of the writes.
- R5: While the link is stalled, posted writes to distinct addresses accumulate up to FIFO depth plus two. All of them are delivered in order once the link resumes.
- R6: `bus_busy` is 1 while a stream byte waits or the address FIFO is full. A write presented while `bus_busy` is 1 is dropped and produces no message.
- R7: The first read of a nonzero address with no read outstanding returns `bus_rnack`=1 and sets the pending bit. It emits one message of kind 3 (read request) with that address and data 0.
- R8: Repeating the read of the outstanding address before its reply arrives returns `bus_rnack`=1, keeps the request pending and emits no further message.
- R9: A reply (`rep_valid`) for the outstanding address sets the valid bit. The next read of that address returns `rep_data` with `bus_rnack`=0 and clears both status bits.
- R10: A read of a different nonzero address while a read is outstanding returns `bus_rnack`=1 and emits no message.
- R11: When several sources wait, the message order is: a waiting stream byte first, then an unsent read request, then a staged configuration message.
- R12: Address 0x41 is an ordinary register: a write there yields a kind 2 message with address 0x41.
- R13: A read of address 0x00 returns status with bit 0 = read pending and bit 1 = read valid. It has no side effect on the handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_addr | input | AW | Host register address |
| bus_wdata | input | DW | Host write data |
| bus_busy | output | 1 | Writes are not accepted while high |
| bus_rack | output | 1 | Read response valid, one cycle after `bus_rd` |
| bus_rnack | output | 1 | With `bus_rack`: remote value not ready |
| bus_rdata | output | DW | Read response data |
| msg_valid | output | 1 | Outgoing message valid |
| msg_ready | input | 1 | Link engine accepts the message |
| msg_kind | output | 2 | 1 stream, 2 configuration, 3 read request |
| msg_addr | output | AW | Message register address |
| msg_data | output | DW | Message data |
| rep_valid | input | 1 | Reply message from the remote side |
| rep_addr | input | AW | Reply register address |
| rep_data | input | DW | Reply value |

## Verification
The bench stalls the link and piles sources up behind one occupied output slot. A wrong priority order, or a stream byte that is lost when the slot is busy, shows up as messages reordered or missing. It fills the posted-write path to exactly its capacity and then writes once more. A design that counts capacity wrongly either raises busy too late, which loses or duplicates entries, or lets the extra write through. It repeats the same read, and reads a different address, before the reply comes back. A design that re-arms the request sends duplicate read messages or overwrites the outstanding address, and one that sets valid too early returns stale data without the not-ready flag.

// File: rtl/sc_bridge_pkg.sv
package sc_bridge_pkg;
  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_STREAM = 2'd1,
    KIND_CFG    = 2'd2,
    KIND_RDREQ  = 2'd3
  } msg_kind_e;

  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_HOLD   = 3'd1,
    SRC_DIRECT = 3'd2,
    SRC_RDREQ  = 3'd3,
    SRC_CFG    = 3'd4
  } msg_src_e;
endpackage

// File: rtl/sc_dp_ram.sv
module sc_dp_ram #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  // one write port, one registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/sc_addr_fifo.sv
module sc_addr_fifo #(
  parameter int W     = 7,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R6: the write decoder must hold writes off while the queue is full
  assert_no_overflow_R6 : assert property (@(posedge clk) disable iff (rst)
    push |-> !full) else $error("address fifo overflow");

  // R4: the packetizer only takes an address that is present
  assert_no_underflow_R4 : assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty) else $error("address fifo underflow");
endmodule

// File: rtl/sc_read_ctl.sv
module sc_read_ctl #(
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_go,
  input  logic [AW-1:0] rd_addr,
  input  logic          rep_valid,
  input  logic [AW-1:0] rep_addr,
  input  logic          req_taken,
  output logic          pend,
  output logic          valid,
  output logic          req_unsent,
  output logic [AW-1:0] req_addr,
  output logic          nack_q
);
  logic remote_rd, hit, consume;

  assign remote_rd = rd_go && (rd_addr != '0);
  assign hit       = valid && (rd_addr == req_addr);
  assign consume   = remote_rd && pend && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      valid      <= 1'b0;
      req_unsent <= 1'b0;
      req_addr   <= '0;
      nack_q     <= 1'b0;
    end else begin
      if (req_taken) req_unsent <= 1'b0;
      if (rd_go) begin
        if (!remote_rd) begin
          nack_q <= 1'b0;
        end else if (!pend) begin
          pend       <= 1'b1;
          req_addr   <= rd_addr;
          req_unsent <= 1'b1;
          nack_q     <= 1'b1;
        end else if (hit) begin
          pend   <= 1'b0;
          valid  <= 1'b0;
          nack_q <= 1'b0;
        end else begin
          nack_q <= 1'b1;
        end
      end
      if (rep_valid && pend && !valid && !consume && (rep_addr == req_addr))
        valid <= 1'b1;
    end
  end

  // R9: a fetched value only exists for an outstanding request
  assert_valid_needs_pend_R9 : assert property (@(posedge clk) disable iff (rst)
    valid |-> pend) else $error("read valid without pending request");

  // R8: an early repeat read neither drops nor retargets the request
  assert_retry_keeps_req_R8 : assert property (@(posedge clk) disable iff (rst)
    (remote_rd && pend && !valid) |=> (pend && $stable(req_addr)))
    else $error("retry disturbed outstanding read");
endmodule

// File: rtl/sc_reg_bridge.sv
module sc_reg_bridge
  import sc_bridge_pkg::*;
#(
  parameter int AW         = 7,
  parameter int DW         = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_busy,
  output logic          bus_rack,
  output logic          bus_rnack,
  output logic [DW-1:0] bus_rdata,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [1:0]    msg_kind,
  output logic [AW-1:0] msg_addr,
  output logic [DW-1:0] msg_data,
  input  logic          rep_valid,
  input  logic [AW-1:0] rep_addr,
  input  logic [DW-1:0] rep_data
);
  localparam int CSR_PAD = DW - 2;
  localparam logic [AW-1:0] STREAM_ADDR = '0;

  // ---------------- access decode ----------------
  logic wr_ok, stream_wr, reg_wr, rd_go;
  logic hold_v;
  logic [DW-1:0] hold_data;
  logic fifo_empty, fifo_full;

  assign bus_busy  = hold_v || fifo_full;
  assign wr_ok     = bus_wr && !bus_rd && !bus_busy;
  assign stream_wr = wr_ok && (bus_addr == STREAM_ADDR);
  assign reg_wr    = wr_ok && (bus_addr != STREAM_ADDR);
  assign rd_go     = bus_rd && !bus_wr;

  // ---------------- posted write path ----------------
  logic [AW-1:0] fifo_head;
  logic          pop;
  logic [DW-1:0] wram_q;
  logic          stg_v, stg_take;
  logic [AW-1:0] stg_addr;

  sc_addr_fifo #(.W(AW), .DEPTH(FIFO_DEPTH)) u_addr_fifo (
    .clk(clk), .rst(rst),
    .push(reg_wr), .din(bus_addr),
    .pop(pop), .head(fifo_head),
    .empty(fifo_empty), .full(fifo_full)
  );

  sc_dp_ram #(.AW(AW), .DW(DW)) u_wr_ram (
    .clk(clk),
    .wr_en(reg_wr), .wr_addr(bus_addr), .wr_data(bus_wdata),
    .rd_en(pop), .rd_addr(fifo_head), .rd_data(wram_q)
  );

  assign pop = !fifo_empty && (!stg_v || stg_take);

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_v    <= 1'b0;
      stg_addr <= '0;
    end else if (pop) begin
      stg_v    <= 1'b1;
      stg_addr <= fifo_head;
    end else if (stg_take) begin
      stg_v    <= 1'b0;
    end
  end

  // ---------------- read handshake ----------------
  logic          rq_pend, rq_valid, rq_unsent, rq_taken, nack_q;
  logic [AW-1:0] rq_addr;
  logic [DW-1:0] rram_q;

  sc_read_ctl #(.AW(AW)) u_read_ctl (
    .clk(clk), .rst(rst),
    .rd_go(rd_go), .rd_addr(bus_addr),
    .rep_valid(rep_valid), .rep_addr(rep_addr),
    .req_taken(rq_taken),
    .pend(rq_pend), .valid(rq_valid),
    .req_unsent(rq_unsent), .req_addr(rq_addr),
    .nack_q(nack_q)
  );

  sc_dp_ram #(.AW(AW), .DW(DW)) u_rd_ram (
    .clk(clk),
    .wr_en(rep_valid), .wr_addr(rep_addr), .wr_data(rep_data),
    .rd_en(rd_go), .rd_addr(bus_addr), .rd_data(rram_q)
  );

  logic          rack_q, csr_sel_q;
  logic [DW-1:0] csr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rack_q    <= 1'b0;
      csr_sel_q <= 1'b0;
      csr_q     <= '0;
    end else begin
      rack_q <= rd_go;
      if (rd_go) begin
        csr_sel_q <= (bus_addr == STREAM_ADDR);
        csr_q     <= {{CSR_PAD{1'b0}}, rq_valid, rq_pend};
      end
    end
  end

  assign bus_rack  = rack_q;
  assign bus_rnack = rack_q && nack_q && !csr_sel_q;
  assign bus_rdata = csr_sel_q ? csr_q : (nack_q ? '0 : rram_q);

  // ---------------- message arbiter ----------------
  msg_src_e      sel;
  logic          out_free, load;
  msg_kind_e     nx_kind;
  logic [AW-1:0] nx_addr;
  logic [DW-1:0] nx_data;

  assign out_free = !msg_valid || msg_ready;

  always_comb begin
    if (hold_v)         sel = SRC_HOLD;
    else if (stream_wr) sel = SRC_DIRECT;
    else if (rq_unsent) sel = SRC_RDREQ;
    else if (stg_v)     sel = SRC_CFG;
    else                sel = SRC_NONE;
  end

  assign load     = out_free && (sel != SRC_NONE);
  assign stg_take = load && (sel == SRC_CFG);
  assign rq_taken = load && (sel == SRC_RDREQ);

  always_comb begin
    nx_kind = KIND_NONE;
    nx_addr = '0;
    nx_data = '0;
    case (sel)
      SRC_HOLD:   begin nx_kind = KIND_STREAM; nx_data = hold_data; end
      SRC_DIRECT: begin nx_kind = KIND_STREAM; nx_data = bus_wdata; end
      SRC_RDREQ:  begin nx_kind = KIND_RDREQ;  nx_addr = rq_addr; end
      SRC_CFG:    begin nx_kind = KIND_CFG;    nx_addr = stg_addr; nx_data = wram_q; end
      default:    ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_v    <= 1'b0;
      hold_data <= '0;
    end else if (stream_wr && !out_free) begin
      hold_v    <= 1'b1;
      hold_data <= bus_wdata;
    end else if (load && (sel == SRC_HOLD)) begin
      hold_v    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_kind  <= 2'd0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load) begin
      msg_valid <= 1'b1;
      msg_kind  <= nx_kind;
      msg_addr  <= nx_addr;
      msg_data  <= nx_data;
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

  // R3: a stalled message stays put until the link takes it
  assert_msg_hold_R3 : assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=>
      (msg_valid && $stable(msg_kind) && $stable(msg_addr) && $stable(msg_data)))
    else $error("message changed while stalled");

  // R11: a waiting stream byte wins the next free slot
  assert_stream_first_R11 : assert property (@(posedge clk) disable iff (rst)
    (hold_v && out_free) |=> (msg_valid && msg_kind == 2'd1))
    else $error("stream byte lost priority");

  // R6: a byte waiting for the slot keeps the bus busy
  assert_busy_on_hold_R6 : assert property (@(posedge clk) disable iff (rst)
    hold_v |-> bus_busy) else $error("busy low with waiting stream byte");
endmodule

// File: tb/tb_sc_reg_bridge.sv
module tb_sc_reg_bridge;
  localparam int AW = 7;
  localparam int DW = 8;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_busy, bus_rack, bus_rnack;
  logic [DW-1:0] bus_rdata;
  logic msg_valid;
  logic msg_ready = 1'b1;
  logic [1:0] msg_kind;
  logic [AW-1:0] msg_addr;
  logic [DW-1:0] msg_data;
  logic rep_valid = 0;
  logic [AW-1:0] rep_addr = '0;
  logic [DW-1:0] rep_data = '0;

  int nchk = 0, nerr = 0, lcount = 0;
  bit done = 0;
  logic [1:0]    lk [64];
  logic [AW-1:0] la [64];
  logic [DW-1:0] ld [64];

  always #2 clk = ~clk;

  sc_reg_bridge #(.AW(AW), .DW(DW), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_busy(bus_busy), .bus_rack(bus_rack), .bus_rnack(bus_rnack), .bus_rdata(bus_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_addr(msg_addr), .msg_data(msg_data),
    .rep_valid(rep_valid), .rep_addr(rep_addr), .rep_data(rep_data)
  );

  always @(posedge clk) begin
    if (!rst && msg_valid && msg_ready && lcount < 64) begin
      lk[lcount] = msg_kind;
      la[lcount] = msg_addr;
      ld[lcount] = msg_data;
      lcount = lcount + 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic nack, output logic [DW-1:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    check("rack", int'(bus_rack), 1);
    nack = bus_rnack;
    d = bus_rdata;
  endtask

  task automatic reply(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    rep_valid = 1; rep_addr = a; rep_data = d;
    @(negedge clk);
    rep_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_msg(input string tag, input int idx, input int k, input int a, input int d);
    check({tag, " kind"}, int'(lk[idx]), k);
    check({tag, " addr"}, int'(la[idx]), a);
    check({tag, " data"}, int'(ld[idx]), d);
  endtask

  task automatic t_reset;
    logic n; logic [DW-1:0] d;
    check("R1 msg_valid", int'(msg_valid), 0);
    check("R1 busy", int'(bus_busy), 0);
    bus_read(0, n, d);
    check("R1 csr", int'(d), 0);
    check("R1 nack", int'(n), 0);
  endtask

  task automatic t_stream;
    int base = lcount;
    bus_write(0, 8'hA5);
    check("R2 immediate valid", int'(msg_valid), 1);
    check("R2 immediate kind", int'(msg_kind), 1);
    idle(3);
    check("R2 count", lcount - base, 1);
    expect_msg("R2", base, 1, 0, 8'hA5);
  endtask

  task automatic t_cfg;
    int base = lcount;
    bus_write(7'h05, 8'h11);
    bus_write(7'h41, 8'h22);
    bus_write(7'h7F, 8'h33);
    idle(8);
    check("R4 count", lcount - base, 3);
    expect_msg("R4 first", base, 2, 7'h05, 8'h11);
    expect_msg("R12 addr41", base + 1, 2, 7'h41, 8'h22);
    expect_msg("R4 third", base + 2, 2, 7'h7F, 8'h33);
  endtask

  task automatic t_fill;
    int base = lcount;
    msg_ready = 0;
    for (int i = 0; i < DEPTH + 2; i++) bus_write(7'(8'h20 + i), 8'(8'h80 + i));
    idle(2);
    check("R6 busy when full", int'(bus_busy), 1);
    bus_write(7'h3C, 8'hEE);
    check("R3 stalled head addr", int'(msg_addr), 7'h20);
    @(negedge clk); msg_ready = 1;
    idle(30);
    check("R5 delivered", lcount - base, DEPTH + 2);
    for (int i = 0; i < DEPTH + 2; i++)
      expect_msg("R5 order", base + i, 2, 8'h20 + i, 8'h80 + i);
    check("R6 busy released", int'(bus_busy), 0);
  endtask

  task automatic t_read;
    logic n; logic [DW-1:0] d;
    int base = lcount;
    bus_read(7'h33, n, d);
    check("R7 first nack", int'(n), 1);
    idle(3);
    check("R7 request count", lcount - base, 1);
    expect_msg("R7 request", base, 3, 7'h33, 0);
    bus_read(0, n, d);
    check("R13 pending bit", int'(d), 1);
    bus_read(7'h33, n, d);
    check("R8 retry nack", int'(n), 1);
    bus_read(7'h34, n, d);
    check("R10 other nack", int'(n), 1);
    idle(3);
    check("R8 R10 no new request", lcount - base, 1);
    bus_read(0, n, d);
    check("R8 still pending", int'(d), 1);
    reply(7'h33, 8'h5C);
    bus_read(0, n, d);
    check("R9 valid bit", int'(d), 3);
    bus_read(7'h33, n, d);
    check("R9 nack clear", int'(n), 0);
    check("R9 data", int'(d), 8'h5C);
    bus_read(0, n, d);
    check("R9 status cleared", int'(d), 0);
  endtask

  task automatic t_priority;
    logic n; logic [DW-1:0] d;
    int base = lcount;
    msg_ready = 0;
    bus_write(7'h50, 8'h01);
    idle(4);
    bus_write(7'h51, 8'h02);
    bus_read(7'h52, n, d);
    bus_write(0, 8'h77);
    idle(1);
    check("R6 busy on waiting stream", int'(bus_busy), 1);
    check("R3 held kind", int'(msg_kind), 2);
    check("R3 held addr", int'(msg_addr), 7'h50);
    @(negedge clk); msg_ready = 1;
    idle(8);
    check("R11 count", lcount - base, 4);
    expect_msg("R11 slot", base, 2, 7'h50, 8'h01);
    expect_msg("R11 stream", base + 1, 1, 0, 8'h77);
    expect_msg("R11 rdreq", base + 2, 3, 7'h52, 0);
    expect_msg("R11 cfg", base + 3, 2, 7'h51, 8'h02);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog R1 actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk); rst = 0;
    t_reset();
    t_stream();
    t_cfg();
    t_fill();
    t_read();
    t_priority();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule